// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block supervises software from a clock domain of its own. A free-running watchdog clock drives a tick counter. If software does not issue a clear request before the counter reaches its programmed limit, the block raises a timeout. The watchdog clock keeps running while the core sleeps and the main clock may be stopped. A timeout in run mode produces a reset pulse. A timeout while asleep produces only a wake pulse, so execution resumes without a reset. An active-low timeout flag tells software afterwards that the watchdog caused the event.

An optional power-of-two divider can be placed in front of the counter through an option input, which lengthens the timeout by up to 128 times. Whenever the watchdog is restarted, by a clear, a sleep entry, a timeout or being disabled, the divider and the counter both return to zero. Requests and option settings come from the main clock domain and cross into the watchdog domain. Events return as one-cycle pulses on the main clock.

The watchdog domain holds a three-state machine:
- **WD_OFF**: the strap is low and everything is held at zero.
- **WD_RUN**: counting while the core is awake.
- **WD_SLEEP**: counting while the core is asleep.

Its transitions are:
- **enable**: OFF to RUN when the strap goes high.
- **doze**: RUN to SLEEP on a sleep request.
- **rouse**: SLEEP to RUN, on a clear request or on a sleep-mode timeout.
- **strap-off**: any state to OFF when the strap goes low.

A timeout in RUN keeps the machine in RUN.

Top module: `wdog_presc`

## Requirements
- R1: While `rst_n` is low, `to_n` is 1 and both `wdt_reset` and `wdt_wake` are 0. After release with the strap high, the first event is a reset pulse, arriving about TIMEOUT_TICKS watchdog cycles later.
- R2: With `presc_to_wdt` low and no clears, `wdt_reset` pulses repeatedly, exactly TIMEOUT_TICKS watchdog cycles apart.
- R3: With `presc_to_wdt` high, a code k on `ratio_sel` (0 to 7) selects division by 2^k. Consecutive timeouts are then exactly TIMEOUT_TICKS·2^k watchdog cycles apart.
- R4: A clear request restarts both the counter and the prescaler from zero. Clears issued more often than the timeout period prevent every event. After the last clear, the event arrives TIMEOUT_TICKS·2^k plus 2 to 6 watchdog cycles of crossing latency later.
- R5: A sleep request restarts the counter and prescaler and enters sleep mode. A timeout while asleep gives a `wdt_wake` pulse and no reset, and returns the block to run mode, so the next event, exactly one period later, is a reset. A clear request while asleep also returns the block to run mode.
- R6: While `en_strap` is low, neither `wdt_reset` nor `wdt_wake` ever pulses. Raising the strap starts a fresh full period.
- R7: `to_n` is set to 1 by reset, by a clear request and by a sleep request. It is cleared to 0 in the cycle after a reset or wake pulse. When both happen in the same cycle, the timeout wins.
- R8: `wdt_reset` and `wdt_wake` each stay high for exactly one `clk` cycle, and they are never high together.
- R9: With `presc_to_wdt` low, `ratio_sel` has no effect and the division ratio is 1:1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| wdt_clk | input | 1 | Independent watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| en_strap | input | 1 | Configuration enable; low disables the watchdog |
| clr_req | input | 1 | One-cycle clear request (main domain) |
| sleep_req | input | 1 | One-cycle sleep-entry request (main domain) |
| presc_to_wdt | input | 1 | 1 assigns the prescaler to the watchdog |
| ratio_sel | input | SEL_W | Prescaler code k, divide by 2^k |
| wdt_reset | output | 1 | One-cycle reset pulse on a run-mode timeout |
| wdt_wake | output | 1 | One-cycle wake pulse on a sleep-mode timeout |
| to_n | output | 1 | Active-low timeout flag |

## Verification
The bench measures the spacing between successive events in watchdog cycles, so a counter or prescaler that is off by one in its terminal compare gives a wrong period. It feeds the watchdog at an interval that leaves the prescaler at varying phases, so a clear that failed to zero the divider would shorten the next timeout below its lower bound. It sends the block to sleep and checks that the first timeout gives a wake and not a reset, and that the block then returns to run mode. It also checks the flag polarity around each event, and that a low strap keeps the block silent for several periods.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_RUN   = 2'd1,
        WD_SLEEP = 2'd2
    } wd_state_e;

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             assign_wdt,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [SEL_W-1:0] eff_sel;

    always_comb begin
        eff_sel = assign_wdt ? sel : '0;
        limit   = (CNT_W'(1) << eff_sel) - CNT_W'(1);
        tick    = (cnt_q >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (clr || tick) cnt_q <= '0;
        else                  cnt_q <= cnt_q + CNT_W'(1);
    end

    // R9: an unassigned prescaler passes every watchdog cycle through
    a_r9_bypass_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !assign_wdt |-> tick);

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 18000,
    parameter int CNT_W         = $clog2(TIMEOUT_TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr_ev,
    input  logic slp_ev,
    input  logic tick,
    output logic pre_clr,
    output logic rst_ev,
    output logic wake_ev
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_TICKS - 1);

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             active, timeout;

    always_comb begin
        active  = (state_q != WD_OFF);
        timeout = active && tick && (cnt_q == CNT_LAST) && !clr_ev && !slp_ev;
        pre_clr = !active || clr_ev || slp_ev || timeout;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:   if (en) state_d = WD_RUN;
            WD_RUN:   if (slp_ev) state_d = WD_SLEEP;
            WD_SLEEP: if (clr_ev || timeout) state_d = WD_RUN;
            default:  state_d = WD_OFF;
        endcase
        if (!en) state_d = WD_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (pre_clr) cnt_q <= '0;
        else if (tick)    cnt_q <= cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_ev  <= 1'b0;
            wake_ev <= 1'b0;
        end else begin
            rst_ev  <= timeout && (state_q == WD_RUN);
            wake_ev <= timeout && (state_q == WD_SLEEP);
        end
    end

    // R6: a disabled watchdog never raises an event
    a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_OFF) |=> (!rst_ev && !wake_ev));

    // R5: the sleep state never leads to a reset event
    a_r5_no_reset_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_SLEEP) |=> !rst_ev);

    // R5: a wake event always leaves the sleep state behind
    a_r5_wake_leaves_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        wake_ev |-> (state_q != WD_SLEEP));

    // R4: a clear suppresses any event on the following edge
    a_r4_clear_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ev |=> (!rst_ev && !wake_ev));

    // R2: the tick counter never passes its terminal value
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);

endmodule

// File: rtl/wdog_presc.sv
module wdog_presc #(
    parameter int TIMEOUT_TICKS = 18000,
    parameter int SEL_W         = 3,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             wdt_clk,
    input  logic             rst_n,
    input  logic             en_strap,
    input  logic             clr_req,
    input  logic             sleep_req,
    input  logic             presc_to_wdt,
    input  logic [SEL_W-1:0] ratio_sel,
    output logic             wdt_reset,
    output logic             wdt_wake,
    output logic             to_n
);

    localparam int CNT_W = $clog2(TIMEOUT_TICKS);
    localparam int FWD_W = SEL_W + 4;

    // main domain: request toggles
    logic clr_tgl_q, slp_tgl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_tgl_q <= 1'b0;
            slp_tgl_q <= 1'b0;
        end else begin
            clr_tgl_q <= clr_tgl_q ^ clr_req;
            slp_tgl_q <= slp_tgl_q ^ sleep_req;
        end
    end

    // crossing into the watchdog domain
    logic [FWD_W-1:0] fwd_s;
    logic             en_w, psa_w, clr_s, slp_s;
    logic [SEL_W-1:0] sel_w;

    wdt_sync #(.W(FWD_W), .STAGES(SYNC_STAGES)) u_fwd_sync (
        .clk   (wdt_clk),
        .rst_n (rst_n),
        .d     ({en_strap, presc_to_wdt, ratio_sel, clr_tgl_q, slp_tgl_q}),
        .q     (fwd_s)
    );

    assign {en_w, psa_w, sel_w, clr_s, slp_s} = fwd_s;

    logic clr_seen_q, slp_seen_q, clr_ev, slp_ev;

    always_ff @(posedge wdt_clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_seen_q <= 1'b0;
            slp_seen_q <= 1'b0;
        end else begin
            clr_seen_q <= clr_s;
            slp_seen_q <= slp_s;
        end
    end

    assign clr_ev = clr_s ^ clr_seen_q;
    assign slp_ev = slp_s ^ slp_seen_q;

    // watchdog domain datapath
    logic tick, pre_clr, rst_ev, wake_ev;

    wdt_prescaler #(.SEL_W(SEL_W)) u_presc (
        .clk        (wdt_clk),
        .rst_n      (rst_n),
        .clr        (pre_clr),
        .assign_wdt (psa_w),
        .sel        (sel_w),
        .tick       (tick)
    );

    wdt_core #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .CNT_W(CNT_W)) u_core (
        .clk     (wdt_clk),
        .rst_n   (rst_n),
        .en      (en_w),
        .clr_ev  (clr_ev),
        .slp_ev  (slp_ev),
        .tick    (tick),
        .pre_clr (pre_clr),
        .rst_ev  (rst_ev),
        .wake_ev (wake_ev)
    );

    // event toggles back to the main domain
    logic rst_tgl_q, wake_tgl_q;

    always_ff @(posedge wdt_clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_tgl_q  <= 1'b0;
            wake_tgl_q <= 1'b0;
        end else begin
            rst_tgl_q  <= rst_tgl_q ^ rst_ev;
            wake_tgl_q <= wake_tgl_q ^ wake_ev;
        end
    end

    logic [1:0] back_s;
    logic       rst_seen_q, wake_seen_q;

    wdt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_back_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({rst_tgl_q, wake_tgl_q}),
        .q     (back_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_seen_q  <= 1'b0;
            wake_seen_q <= 1'b0;
        end else begin
            rst_seen_q  <= back_s[1];
            wake_seen_q <= back_s[0];
        end
    end

    assign wdt_reset = back_s[1] ^ rst_seen_q;
    assign wdt_wake  = back_s[0] ^ wake_seen_q;

    // timeout flag, timeout has priority
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      to_n <= 1'b1;
        else if (wdt_reset || wdt_wake)  to_n <= 1'b0;
        else if (clr_req || sleep_req)   to_n <= 1'b1;
    end

    // R8: reset pulse lasts a single main cycle
    a_r8_reset_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |=> !wdt_reset);

    // R8: wake pulse lasts a single main cycle
    a_r8_wake_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_wake |=> !wdt_wake);

    // R7: any event leaves the flag low
    a_r7_flag_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_reset || wdt_wake) |=> !to_n);

endmodule

// File: tb/wdog_presc_test.sv
module wdog_presc_test;

    localparam int T = 16;

    logic       clk = 1'b0, wclk = 1'b0, rst_n = 1'b0;
    logic       en = 1'b1, clr = 1'b0, slp = 1'b0, psa = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       wdt_reset, wdt_wake, to_n;

    wdog_presc #(.TIMEOUT_TICKS(T), .SEL_W(3), .SYNC_STAGES(2)) uut (
        .clk(clk), .wdt_clk(wclk), .rst_n(rst_n), .en_strap(en),
        .clr_req(clr), .sleep_req(slp), .presc_to_wdt(psa), .ratio_sel(sel),
        .wdt_reset(wdt_reset), .wdt_wake(wdt_wake), .to_n(to_n)
    );

    always #2 clk = ~clk;
    always #7 wclk = ~wclk;

    int unsigned wcount = 0;
    always @(posedge wclk) wcount <= wcount + 1;

    int checks = 0, fails = 0, n_evt = 0;
    bit prev_r = 1'b0, prev_w = 1'b0, done = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R8 monitor on pulse shape
    always @(negedge clk) begin
        if (rst_n) begin
            if (wdt_reset || wdt_wake) begin
                n_evt++;
                chk(!(wdt_reset && wdt_wake), "R8 both pulses together", 1, 0);
            end
            if (wdt_reset) chk(!prev_r, "R8 reset pulse width", 2, 1);
            if (wdt_wake)  chk(!prev_w, "R8 wake pulse width", 2, 1);
            prev_r = wdt_reset;
            prev_w = wdt_wake;
        end
    end

    task automatic wcyc(input int n);
        repeat (n) @(posedge wclk);
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    task automatic pulse_slp();
        @(negedge clk) slp = 1'b1;
        @(negedge clk) slp = 1'b0;
    endtask

    // kind: 0 none, 1 reset, 2 wake
    task automatic wait_evt(output int kind, output int unsigned at, input int limit_w);
        int unsigned start;
        bit found;
        start = wcount;
        kind = 0;
        at = 0;
        found = 1'b0;
        while (!found && (wcount - start) < limit_w) begin
            @(negedge clk);
            if (wdt_reset || wdt_wake) begin
                kind  = wdt_reset ? 1 : 2;
                at    = wcount;
                found = 1'b1;
            end
        end
    endtask

    task automatic settle(input bit p, input logic [2:0] s);
        psa = p;
        sel = s;
        wcyc(4);
        pulse_clr();
        wcyc(4);
    endtask

    task automatic t_reset();
        int k;
        int unsigned t0, a;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(to_n == 1'b1, "R1 flag during reset", to_n, 1);
        chk(!wdt_reset && !wdt_wake, "R1 pulses during reset", {wdt_reset, wdt_wake}, 0);
        t0 = wcount;
        rst_n = 1'b1;
        wait_evt(k, a, T + 20);
        chk(k == 1, "R1 first event kind", k, 1);
        chk((a - t0) >= T + 2 && (a - t0) <= T + 6, "R1 first event delay", a - t0, T + 4);
    endtask

    task automatic t_period(input bit p, input logic [2:0] s, input int scale, input string tag);
        int k1, k2;
        int unsigned t0, a1, a2;
        int e;
        e = T * scale;
        settle(p, s);
        t0 = wcount;
        pulse_clr();
        wait_evt(k1, a1, e + 20);
        chk(k1 == 1, {tag, " first event kind"}, k1, 1);
        chk((a1 - t0) >= e + 2 && (a1 - t0) <= e + 6, {tag, " delay after clear"}, a1 - t0, e + 4);
        @(negedge clk);
        chk(to_n == 1'b0, "R7 flag low after reset pulse", to_n, 0);
        wait_evt(k2, a2, e + 20);
        chk(k2 == 1 && (a2 - a1) == e, {tag, " period"}, a2 - a1, e);
    endtask

    task automatic t_feed();
        int k, n0;
        int unsigned t0, a;
        int e;
        e = T * 8;
        settle(1'b1, 3'd3);
        n0 = n_evt;
        for (int i = 0; i < 12; i++) begin
            pulse_clr();
            wcyc(e / 2 + 3);
        end
        chk(n_evt == n0, "R4 fed watchdog stays quiet", n_evt - n0, 0);
        t0 = wcount;
        pulse_clr();
        wait_evt(k, a, e + 20);
        chk(k == 1, "R4 event after feeding stops", k, 1);
        chk((a - t0) >= e + 2 && (a - t0) <= e + 6, "R4 restart of counter and prescaler", a - t0, e + 4);
    endtask

    task automatic t_sleep(input bit p, input logic [2:0] s, input int scale);
        int k1, k2;
        int unsigned t0, a1, a2;
        int e;
        e = T * scale;
        psa = p;
        sel = s;
        wcyc(4);
        t0 = wcount;
        pulse_slp();
        chk(to_n == 1'b1, "R7 sleep request sets flag", to_n, 1);
        wait_evt(k1, a1, e + 20);
        chk(k1 == 2, "R5 sleep timeout gives wake", k1, 2);
        chk((a1 - t0) >= e + 2 && (a1 - t0) <= e + 6, "R5 sleep restart delay", a1 - t0, e + 4);
        @(negedge clk);
        chk(to_n == 1'b0, "R7 flag low after wake pulse", to_n, 0);
        wait_evt(k2, a2, e + 20);
        chk(k2 == 1 && (a2 - a1) == e, "R5 back to run after wake", a2 - a1, e);
    endtask

    task automatic t_sleep_clear();
        int k;
        int unsigned a;
        settle(1'b0, 3'd0);
        pulse_slp();
        wcyc(T / 2);
        pulse_clr();
        chk(to_n == 1'b1, "R7 clear request sets flag", to_n, 1);
        wait_evt(k, a, T + 20);
        chk(k == 1, "R5 clear while asleep returns to run", k, 1);
    endtask

    task automatic t_disable();
        int k, n0;
        int unsigned t0, a;
        psa = 1'b0;
        en = 1'b0;
        wcyc(4);
        n0 = n_evt;
        wcyc(5 * T);
        chk(n_evt == n0, "R6 disabled watchdog silent", n_evt - n0, 0);
        t0 = wcount;
        en = 1'b1;
        wait_evt(k, a, T + 20);
        chk(k == 1, "R6 re-enable event kind", k, 1);
        chk((a - t0) >= T + 2 && (a - t0) <= T + 6, "R6 re-enable full period", a - t0, T + 4);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL bench hung, all requirements actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_period(1'b0, 3'd6, 1, "R9 ratio ignored unassigned");
        t_period(1'b0, 3'd0, 1, "R2 run-mode timeout");
        t_period(1'b1, 3'd0, 1, "R3 ratio code 0");
        t_period(1'b1, 3'd3, 8, "R3 ratio code 3");
        t_period(1'b1, 3'd7, 128, "R3 ratio code 7");
        t_feed();
        t_sleep(1'b0, 3'd0, 1);
        t_sleep(1'b1, 3'd2, 4);
        t_sleep_clear();
        t_disable();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule